// File: doc/BRIEF.md
# Secondary CPU power-domain shutdown sequencer

This block takes up to three secondary CPU power domains down in hardware, one domain at a time. For every domain it owns a seven-bit control vector that drives the domain's isolation cells, SRAM isolation, reset, clock gate and two power switches. It changes one bit per step, and between steps it waits a fixed settle interval. Partway through each domain it hands over to the L1 cache power-down logic with a request and waits for the acknowledge. It counts a domain as off only when both power-switch status chains report that domain low.

Software first unlocks the sequencer with a keyed configuration write and then pulses a start input. The sequencer works through core 1, core 2 and core 3 in turn. When the last core is off it raises a single-cycle completion pulse and goes idle. The control vectors keep their final powered-off values until the next reset. Powering domains back up is out of scope.

Top module: `cpu_pdn_seq`

## Requirements
- R1: After reset every control vector is 7'b1001101, meaning bit 6 (active-low SRAM internal isolation) high, bit 5 (SRAM clock isolation) low, bit 4 (clock disable) low, bit 3 (second power switch) high, bit 2 (first power switch) high, bit 1 (isolation) low and bit 0 (active-low reset) high. After reset all L1 requests are low, done is low and the sequencer is locked.
- R2: A start pulse is accepted only while unlocked. A configuration write whose upper 16 bits equal KEY and whose bit 0 is 1 unlocks the sequencer. A write with KEY and bit 0 equal to 0 locks it again. A write carrying any other upper half has no effect.
- R3: For each core the first four visible changes are, in order: bit 1 set, bit 5 set, bit 6 cleared, and that core's L1 request raised. Each step changes exactly one output bit.
- R4: After raising a core's L1 request, the sequencer makes no further change until that core's L1 acknowledge is high.
- R5: After the acknowledge, the next four changes are, in order: bit 0 cleared, bit 4 set, bit 2 cleared, bit 3 cleared.
- R6: Two consecutive steps with no wait between them appear SETTLE+1 cycles apart. The default SETTLE is 2, so they appear 3 cycles apart.
- R7: A core is complete only when status bit STA_LSB+i (bits 10, 11 and 12 for cores 1 to 3) is low in both the primary and the secondary status vector. Until then the sequencer holds.
- R8: Cores are handled strictly in the order core 1, core 2, core 3. Core i+1's vector (slice [7*i+6:7*i] of ctrl_o, with core 1 at slice 0) does not change until core i has both power switches cleared.
- R9: done_o is a one-cycle pulse, raised the cycle after the last core is seen complete. The sequencer is then idle.
- R10: A start pulse that arrives while a sequence is running is ignored. A start pulse received when idle again is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse for a shutdown sequence |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_data_i | input | 32 | Configuration write data: key in bits 31:16, enable in bit 0 |
| l1_ack_i | input | NCORE | L1 power-down acknowledge, one bit per core |
| pwr_sta_i | input | STA_W | Primary power-switch status vector |
| pwr_sta2_i | input | STA_W | Secondary power-switch status vector |
| ctrl_o | output | 7*NCORE | Per-core control vectors, core i at bits [7*i+6:7*i] |
| l1_req_o | output | NCORE | L1 power-down request, one bit per core |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Two events can land in the same cycle: the sequencer detecting that the last core is complete, and a fresh start pulse. The bench holds the last core's primary status high, so the sequencer is parked in its final wait. In a single cycle it then releases that status bit and pulses start. The expected outcome is exactly one done pulse and no second sequence; this is judged from the count of done pulses over a window longer than a full run. A later start, given when the sequencer is idle, must produce another done pulse.

// File: rtl/pdn_pkg.sv
package pdn_pkg;

    localparam int CTL_W          = 7;
    localparam int BIT_RST_B      = 0;
    localparam int BIT_ISO        = 1;
    localparam int BIT_SW1        = 2;
    localparam int BIT_SW2        = 3;
    localparam int BIT_CLKOFF     = 4;
    localparam int BIT_SRAM_CKISO = 5;
    localparam int BIT_SRAM_ISO_B = 6;

    // powered-on vector: sram iso_b high, switches on, reset released
    localparam logic [CTL_W-1:0] CTL_ON = 7'b1001101;

    localparam logic [2:0] STEP_L1REQ = 3'd3;
    localparam logic [2:0] STEP_LAST  = 3'd7;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_STEP,
        SQ_GAP,
        SQ_ACK,
        SQ_OFF
    } seq_st_e;

endpackage

// File: rtl/pdn_step_apply.sv
module pdn_step_apply
    import pdn_pkg::*;
(
    input  logic [CTL_W-1:0] vec_i,
    input  logic [2:0]       step_i,
    output logic [CTL_W-1:0] vec_o,
    output logic             req_o
);

    always_comb begin
        vec_o = vec_i;
        req_o = 1'b0;
        unique case (step_i)
            3'd0: vec_o[BIT_ISO]        = 1'b1;
            3'd1: vec_o[BIT_SRAM_CKISO] = 1'b1;
            3'd2: vec_o[BIT_SRAM_ISO_B] = 1'b0;
            3'd3: req_o                 = 1'b1;
            3'd4: vec_o[BIT_RST_B]      = 1'b0;
            3'd5: vec_o[BIT_CLKOFF]     = 1'b1;
            3'd6: vec_o[BIT_SW1]        = 1'b0;
            3'd7: vec_o[BIT_SW2]        = 1'b0;
            default: vec_o = vec_i;
        endcase
    end

endmodule

// File: rtl/pdn_off_detect.sv
module pdn_off_detect #(
    parameter int NCORE   = 3,
    parameter int STA_W   = 16,
    parameter int STA_LSB = 10
) (
    input  logic [STA_W-1:0] sta_i,
    input  logic [STA_W-1:0] sta2_i,
    output logic [NCORE-1:0] off_o
);

    for (genvar i = 0; i < NCORE; i++) begin : g_core
        assign off_o[i] = ~sta_i[STA_LSB+i] & ~sta2_i[STA_LSB+i];
    end

endmodule

// File: rtl/cpu_pdn_seq.sv
module cpu_pdn_seq
    import pdn_pkg::*;
#(
    parameter int          NCORE   = 3,
    parameter int          STA_W   = 16,
    parameter int          STA_LSB = 10,
    parameter int          SETTLE  = 2,
    parameter int          KEY_W   = 16,
    parameter logic [15:0] KEY     = 16'h5A17
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   start_i,
    input  logic                   cfg_wr_i,
    input  logic [2*KEY_W-1:0]     cfg_data_i,
    input  logic [NCORE-1:0]       l1_ack_i,
    input  logic [STA_W-1:0]       pwr_sta_i,
    input  logic [STA_W-1:0]       pwr_sta2_i,
    output logic [NCORE*CTL_W-1:0] ctrl_o,
    output logic [NCORE-1:0]       l1_req_o,
    output logic                   done_o
);

    localparam int CFG_W  = 2 * KEY_W;
    localparam int CORE_W = (NCORE < 2) ? 1 : $clog2(NCORE);
    localparam int CNT_W  = (SETTLE < 2) ? 1 : $clog2(SETTLE + 1);

    typedef struct packed {
        seq_st_e                      st;
        logic [2:0]                   step;
        logic [CORE_W-1:0]            core;
        logic [CNT_W-1:0]             cnt;
        logic [NCORE-1:0][CTL_W-1:0]  ctrl;
        logic [NCORE-1:0]             req;
        logic                         done;
        logic                         unlock;
    } seq_s;

    seq_s q, d;

    logic [CTL_W-1:0] app_vec;
    logic             app_req;
    logic [NCORE-1:0] off_vec;
    seq_st_e          adv_st;
    logic [2:0]       adv_step;

    pdn_step_apply u_apply (
        .vec_i  (q.ctrl[q.core]),
        .step_i (q.step),
        .vec_o  (app_vec),
        .req_o  (app_req)
    );

    pdn_off_detect #(
        .NCORE   (NCORE),
        .STA_W   (STA_W),
        .STA_LSB (STA_LSB)
    ) u_off (
        .sta_i  (pwr_sta_i),
        .sta2_i (pwr_sta2_i),
        .off_o  (off_vec)
    );

    // where the sequence goes once a step and its settle time are over
    always_comb begin
        adv_step = q.step + 3'd1;
        if (q.step == STEP_L1REQ) begin
            adv_st = SQ_ACK;
        end else if (q.step == STEP_LAST) begin
            adv_st = SQ_OFF;
        end else begin
            adv_st = SQ_STEP;
        end
    end

    always_comb begin
        d      = q;
        d.done = 1'b0;

        if (cfg_wr_i && (cfg_data_i[CFG_W-1:KEY_W] == KEY)) begin
            d.unlock = cfg_data_i[0];
        end

        unique case (q.st)
            SQ_IDLE: begin
                if (start_i && q.unlock) begin
                    d.st   = SQ_STEP;
                    d.step = 3'd0;
                    d.core = '0;
                end
            end
            SQ_STEP: begin
                d.ctrl[q.core] = app_vec;
                if (app_req) begin
                    d.req[q.core] = 1'b1;
                end
                if (SETTLE == 0) begin
                    d.st   = adv_st;
                    d.step = adv_step;
                end else begin
                    d.st  = SQ_GAP;
                    d.cnt = CNT_W'(SETTLE - 1);
                end
            end
            SQ_GAP: begin
                if (q.cnt == '0) begin
                    d.st   = adv_st;
                    d.step = adv_step;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            SQ_ACK: begin
                if (l1_ack_i[q.core]) begin
                    d.st = SQ_STEP;
                end
            end
            SQ_OFF: begin
                if (off_vec[q.core]) begin
                    if (q.core == CORE_W'(NCORE - 1)) begin
                        d.done = 1'b1;
                        d.st   = SQ_IDLE;
                    end else begin
                        d.core = q.core + 1'b1;
                        d.step = 3'd0;
                        d.st   = SQ_STEP;
                    end
                end
            end
            default: d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q.st     <= SQ_IDLE;
            q.step   <= 3'd0;
            q.core   <= '0;
            q.cnt    <= '0;
            q.ctrl   <= {NCORE{CTL_ON}};
            q.req    <= '0;
            q.done   <= 1'b0;
            q.unlock <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign ctrl_o   = q.ctrl;
    assign l1_req_o = q.req;
    assign done_o   = q.done;

endmodule

// File: rtl/cpu_pdn_seq_chk.sv
module cpu_pdn_seq_chk
    import pdn_pkg::*;
#(
    parameter int NCORE   = 3,
    parameter int STA_W   = 16,
    parameter int STA_LSB = 10
) (
    input logic                   clk_i,
    input logic                   rst_ni,
    input logic [NCORE-1:0]       l1_ack_i,
    input logic [STA_W-1:0]       pwr_sta_i,
    input logic [STA_W-1:0]       pwr_sta2_i,
    input logic [NCORE*CTL_W-1:0] ctrl_o,
    input logic [NCORE-1:0]       l1_req_o,
    input logic                   done_o
);

    assert_done_pulse_R9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    assert_done_needs_off_R7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(done_o) |-> $past(!pwr_sta_i[STA_LSB+NCORE-1] && !pwr_sta2_i[STA_LSB+NCORE-1]));

    for (genvar i = 0; i < NCORE; i++) begin : g_core
        assert_req_after_iso_R3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(l1_req_o[i]) |-> (ctrl_o[CTL_W*i+BIT_ISO] &&
                                    ctrl_o[CTL_W*i+BIT_SRAM_CKISO] &&
                                    !ctrl_o[CTL_W*i+BIT_SRAM_ISO_B]));

        assert_rst_after_req_R4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
            $fell(ctrl_o[CTL_W*i+BIT_RST_B]) |-> l1_req_o[i]);

        assert_sw2_last_R5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
            $fell(ctrl_o[CTL_W*i+BIT_SW2]) |-> (!ctrl_o[CTL_W*i+BIT_SW1] &&
                                                ctrl_o[CTL_W*i+BIT_CLKOFF] &&
                                                !ctrl_o[CTL_W*i+BIT_RST_B]));

        if (i < NCORE - 1) begin : g_order
            assert_core_order_R8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
                !$stable(ctrl_o[CTL_W*(i+1) +: CTL_W]) |->
                    (!ctrl_o[CTL_W*i+BIT_SW1] && !ctrl_o[CTL_W*i+BIT_SW2]));
        end
    end

endmodule

bind cpu_pdn_seq cpu_pdn_seq_chk #(
    .NCORE   (NCORE),
    .STA_W   (STA_W),
    .STA_LSB (STA_LSB)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .l1_ack_i   (l1_ack_i),
    .pwr_sta_i  (pwr_sta_i),
    .pwr_sta2_i (pwr_sta2_i),
    .ctrl_o     (ctrl_o),
    .l1_req_o   (l1_req_o),
    .done_o     (done_o)
);

// File: tb/tb_cpu_pdn_seq.sv
module tb_cpu_pdn_seq;

    localparam int CLK_PERIOD = 10;
    localparam int NC   = 3;
    localparam int SW   = 16;
    localparam int LSB  = 10;
    localparam int STL  = 2;
    localparam logic [15:0] KEY = 16'h5A17;
    localparam logic [6:0] ON_VEC = 7'b1001101;
    localparam int OBS_W = NC * 7 + NC;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic cfg_wr = 1'b0;
    logic [31:0] cfg_data = '0;
    logic [NC-1:0] l1_ack;
    logic [SW-1:0] sta1, sta2;
    logic [NC*7-1:0] ctrl;
    logic [NC-1:0] l1_req;
    logic done;

    logic [NC-1:0] ack_en = '0;
    logic [NC-1:0] hold1 = '0;
    logic [NC-1:0] hold2 = '0;

    int errs = 0;
    int checks = 0;
    int cyc = 0;
    int done_cnt = 0;
    bit done_prev = 1'b0;
    logic [OBS_W-1:0] exp_q[$];
    int chg_cyc[$];
    logic [OBS_W-1:0] last_obs;

    always #(CLK_PERIOD/2) clk = ~clk;

    // bench model of the power switches and the L1 logic
    assign l1_ack = l1_req & ack_en;
    always_comb begin
        sta1 = '0;
        sta2 = '0;
        for (int i = 0; i < NC; i++) begin
            sta1[LSB+i] = ctrl[7*i+2] | hold1[i];
            sta2[LSB+i] = ctrl[7*i+3] | hold2[i];
        end
    end

    cpu_pdn_seq #(.NCORE(NC), .STA_W(SW), .STA_LSB(LSB), .SETTLE(STL), .KEY(KEY)) dut (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cfg_wr_i(cfg_wr),
        .cfg_data_i(cfg_data), .l1_ack_i(l1_ack), .pwr_sta_i(sta1),
        .pwr_sta2_i(sta2), .ctrl_o(ctrl), .l1_req_o(l1_req), .done_o(done)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [OBS_W-1:0] rst_obs();
        return {{NC{1'b0}}, {NC{ON_VEC}}};
    endfunction

    // driver: expected changes of one full run, from the required order
    task automatic push_run();
        logic [OBS_W-1:0] o;
        o = rst_obs();
        for (int c = 0; c < NC; c++) begin
            o[7*c+1] = 1'b1;  exp_q.push_back(o);
            o[7*c+5] = 1'b1;  exp_q.push_back(o);
            o[7*c+6] = 1'b0;  exp_q.push_back(o);
            o[NC*7+c] = 1'b1; exp_q.push_back(o);
            o[7*c+0] = 1'b0;  exp_q.push_back(o);
            o[7*c+4] = 1'b1;  exp_q.push_back(o);
            o[7*c+2] = 1'b0;  exp_q.push_back(o);
            o[7*c+3] = 1'b0;  exp_q.push_back(o);
        end
    endtask

    // monitor: compares every output change against the queue
    always @(negedge clk) begin
        logic [OBS_W-1:0] cur;
        logic [OBS_W-1:0] e;
        cyc++;
        if (rst_n) begin
            cur = {l1_req, ctrl};
            if (cur !== last_obs) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3 unexpected change", 64'(cur), 64'(last_obs));
                end else begin
                    e = exp_q.pop_front();
                    check(cur === e, "R3 R5 R8 sequence", 64'(cur), 64'(e));
                end
                chg_cyc.push_back(cyc);
                last_obs = cur;
            end
            if (done) done_cnt++;
            if (done && done_prev) check(1'b0, "R9 done width", 64'd2, 64'd1);
            done_prev = done;
        end else begin
            last_obs  = rst_obs();
            done_prev = 1'b0;
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic cfg_write(input logic [31:0] v);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_data = v;
        @(negedge clk);
        cfg_wr = 1'b0;
        cfg_data = '0;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        $display("FAIL watchdog actual=%0d expected=finish", cyc);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        int n;
        // phase A: reset state and the key lock
        do_reset();
        check(ctrl === {NC{ON_VEC}}, "R1 ctrl reset", 64'(ctrl), 64'({NC{ON_VEC}}));
        check(l1_req === '0, "R1 req reset", 64'(l1_req), 64'd0);
        check(done === 1'b0, "R1 done reset", 64'(done), 64'd0);
        pulse_start();
        repeat (20) @(negedge clk);
        check(ctrl === {NC{ON_VEC}}, "R2 locked start", 64'(ctrl), 64'({NC{ON_VEC}}));
        cfg_write({KEY ^ 16'h0001, 16'h0001});
        pulse_start();
        repeat (20) @(negedge clk);
        check(ctrl === {NC{ON_VEC}}, "R2 wrong key", 64'(ctrl), 64'({NC{ON_VEC}}));
        cfg_write({KEY, 16'h0001});
        cfg_write({KEY, 16'h0000});
        pulse_start();
        repeat (20) @(negedge clk);
        check(ctrl === {NC{ON_VEC}}, "R2 relocked", 64'(ctrl), 64'({NC{ON_VEC}}));

        // phase B: full run with a late ack and a held status bit
        do_reset();
        chg_cyc.delete();
        ack_en = '0;
        hold2 = 3'b010;
        cfg_write({KEY, 16'h0001});
        push_run();
        pulse_start();
        n = 0;
        while (!l1_req[0] && n < 300) begin @(negedge clk); n++; end
        repeat (30) @(negedge clk);
        check(ctrl[0] === 1'b1, "R4 stall for ack", 64'(ctrl[0]), 64'd1);
        pulse_start();  // R10: busy, must be ignored
        ack_en = '1;
        n = 0;
        while ((ctrl[9] || ctrl[10]) && n < 600) begin @(negedge clk); n++; end
        repeat (30) @(negedge clk);
        check(ctrl[20:14] === ON_VEC, "R7 core 3 waits", 64'(ctrl[20:14]), 64'(ON_VEC));
        check(done_cnt == 0, "R7 no done", 64'(done_cnt), 64'd0);
        hold2 = '0;
        n = 0;
        while (done_cnt == 0 && n < 600) begin @(negedge clk); n++; end
        repeat (20) @(negedge clk);
        check(done_cnt == 1, "R9 R10 one done", 64'(done_cnt), 64'd1);
        check(exp_q.size() == 0, "R3 R5 R8 all steps seen", 64'(exp_q.size()), 64'd0);
        check(chg_cyc.size() > 1 && chg_cyc[1] - chg_cyc[0] == STL + 1, "R6 settle spacing",
              64'(chg_cyc.size() > 1 ? chg_cyc[1] - chg_cyc[0] : 0), 64'(STL + 1));

        // phase C: start in the cycle the last core completes
        hold1 = 3'b100;
        pulse_start();
        repeat (200) @(negedge clk);
        check(done_cnt == 1, "R7 primary held", 64'(done_cnt), 64'd1);
        hold1 = '0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (30) @(negedge clk);
        check(done_cnt == 2, "R9 done on completion", 64'(done_cnt), 64'd2);
        repeat (200) @(negedge clk);
        check(done_cnt == 2, "R10 same-cycle start ignored", 64'(done_cnt), 64'd2);
        pulse_start();
        repeat (300) @(negedge clk);
        check(done_cnt == 3, "R10 idle start accepted", 64'(done_cnt), 64'd3);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule